// File: doc/BRIEF.md
# Break Return Address Selector

When a debug break is taken, this block decides which program-counter value is saved as the return address. It looks at the instruction that hit the break condition and at the break mode. In before mode, the break fires before the matched instruction runs. In after mode, the matched instruction runs first and the break fires once it completes. It also handles two corner cases: a matched delayed branch, and a matched instruction that sits in a delay slot.

The block keeps one register of issue history, which holds the address of the most recently issued instruction. A break on a delay-slot instruction in before mode returns to that address, which is the branch that owns the slot. Instructions are fixed-length 16-bit, so the next sequential address is the matched address plus 2. A break request strobe samples the inputs. The chosen address is registered, and a one-cycle valid pulse is produced in the cycle after the request.

A small two-state controller drives the output:
- States: `ST_IDLE`, where no result is being presented, and `ST_EMIT`, where the result is valid.
- Transition "request": any state goes to `ST_EMIT` when `brk_req` is high.
- Transition "quiet": any state goes to `ST_IDLE` when `brk_req` is low.

Top module: `brs_top`

## Requirements
- R1: In before mode (`brk_mode`=0), when `match_in_slot`=0, the saved address is `match_addr`. This holds whatever the value of `match_is_dbr`.
- R2: In before mode, when `match_in_slot`=1, the saved address is the history register's value as it stood in the request cycle. This rule takes priority over `match_is_dbr`.
- R3: In after mode (`brk_mode`=1), when `match_is_dbr`=0 and `match_in_slot`=0, the saved address is `match_addr`+2, wrapping modulo 2^AW.
- R4: In after mode, when `match_is_dbr`=1 or `match_in_slot`=1, the saved address is `branch_target`.
- R5: `ret_vld` is high in exactly the cycle after each cycle in which `brk_req` is high, and low otherwise. `ret_addr` updates on that same edge.
- R6: In a cycle with `brk_req` low, `ret_addr` holds its value at the next edge.
- R7: The history register loads `issue_addr` on every edge where `issue_vld` is high. If a delay-slot break in before mode is requested in the same cycle as an issue, it uses the value held before that issue.
- R8: After reset, `ret_addr` is 0, `ret_vld` is 0 and the history register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| issue_addr | input | AW | Address of the issued instruction |
| brk_req | input | 1 | Break request strobe; samples the match inputs |
| brk_mode | input | 1 | 0 = break before execution, 1 = break after execution |
| match_addr | input | AW | Address of the matched instruction |
| match_is_dbr | input | 1 | The matched instruction is a delayed branch |
| match_in_slot | input | 1 | The matched instruction sits in a delay slot |
| branch_target | input | AW | Destination of the associated branch |
| ret_addr | output | AW | Return address to be saved |
| ret_vld | output | 1 | One-cycle strobe: `ret_addr` is fresh |

## Verification
The assertions check several properties on every cycle:
- the valid pulse follows the request one cycle later;
- the address holds when no request is present;
- the history register loads the issued address;
- the saved address is correct in the three cases that depend only on the sampled inputs (before and not in a slot, after and plain, after with a branch or slot).

Some behaviour can only be shown by the bench scenarios:
- the delay-slot case in before mode, where the saved address depends on which instruction was issued earlier;
- the same-cycle ordering of an issue and a request;
- address wrap at the top of the space;
- the reset contents of the history register.

// File: rtl/brs_pkg.sv
package brs_pkg;
    typedef enum logic {
        BRK_BEFORE = 1'b0,
        BRK_AFTER  = 1'b1
    } brk_mode_e;

    typedef enum logic [1:0] {
        SRC_MATCH = 2'd0,
        SRC_HIST  = 2'd1,
        SRC_SEQ   = 2'd2,
        SRC_TGT   = 2'd3
    } ret_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } brs_state_e;
endpackage

// File: rtl/brs_history.sv
module brs_history #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_vld,
    input  logic [AW-1:0] issue_addr,
    output logic [AW-1:0] prev_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_addr <= '0;
        else if (issue_vld) prev_addr <= issue_addr;
    end

    assert_hist_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> prev_addr == $past(issue_addr));
endmodule

// File: rtl/brs_select.sv
module brs_select
    import brs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ILEN_BYTES = 2
) (
    input  brk_mode_e     mode,
    input  logic          is_dbr,
    input  logic          in_slot,
    input  logic [AW-1:0] match_addr,
    input  logic [AW-1:0] hist_addr,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] sel_addr
);
    localparam logic [AW-1:0] STEP = AW'(ILEN_BYTES);

    ret_src_e src;

    always_comb begin
        unique case (mode)
            BRK_BEFORE: src = in_slot ? SRC_HIST : SRC_MATCH;
            BRK_AFTER:  src = (is_dbr || in_slot) ? SRC_TGT : SRC_SEQ;
            default:    src = SRC_MATCH;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_MATCH: sel_addr = match_addr;
            SRC_HIST:  sel_addr = hist_addr;
            SRC_SEQ:   sel_addr = match_addr + STEP;
            SRC_TGT:   sel_addr = target;
            default:   sel_addr = match_addr;
        endcase
    end
endmodule

// File: rtl/brs_top.sv
module brs_top
    import brs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ILEN_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_vld,
    input  logic [AW-1:0] issue_addr,
    input  logic          brk_req,
    input  logic          brk_mode,
    input  logic [AW-1:0] match_addr,
    input  logic          match_is_dbr,
    input  logic          match_in_slot,
    input  logic [AW-1:0] branch_target,
    output logic [AW-1:0] ret_addr,
    output logic          ret_vld
);
    localparam logic [AW-1:0] STEP = AW'(ILEN_BYTES);

    brs_state_e   state, state_nx;
    logic [AW-1:0] hist_addr;
    logic [AW-1:0] sel_addr;

    brs_history #(.AW(AW)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_vld  (issue_vld),
        .issue_addr (issue_addr),
        .prev_addr  (hist_addr)
    );

    brs_select #(.AW(AW), .ILEN_BYTES(ILEN_BYTES)) u_sel (
        .mode       (brk_mode_e'(brk_mode)),
        .is_dbr     (match_is_dbr),
        .in_slot    (match_in_slot),
        .match_addr (match_addr),
        .hist_addr  (hist_addr),
        .target     (branch_target),
        .sel_addr   (sel_addr)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = brk_req ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = brk_req ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ret_addr <= '0;
        else if (brk_req) ret_addr <= sel_addr;
    end

    assign ret_vld = (state == ST_EMIT);

    assert_vld_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> ret_vld);
    assert_no_vld_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |=> !ret_vld);
    assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |=> $stable(ret_addr));
    assert_before_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !brk_mode && !match_in_slot) |=> ret_addr == $past(match_addr));
    assert_after_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && brk_mode && !match_is_dbr && !match_in_slot)
            |=> ret_addr == $past(match_addr) + STEP);
    assert_after_tgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && brk_mode && (match_is_dbr || match_in_slot))
            |=> ret_addr == $past(branch_target));
endmodule

// File: tb/sim_brs_top.sv
module sim_brs_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_vld = 1'b0;
    logic [AW-1:0] issue_addr = '0;
    logic          brk_req = 1'b0;
    logic          brk_mode = 1'b0;
    logic [AW-1:0] match_addr = '0;
    logic          match_is_dbr = 1'b0;
    logic          match_in_slot = 1'b0;
    logic [AW-1:0] branch_target = '0;
    logic [AW-1:0] ret_addr;
    logic          ret_vld;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    brs_top #(.AW(AW), .ILEN_BYTES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_addr(issue_addr),
        .brk_req(brk_req), .brk_mode(brk_mode), .match_addr(match_addr),
        .match_is_dbr(match_is_dbr), .match_in_slot(match_in_slot),
        .branch_target(branch_target), .ret_addr(ret_addr), .ret_vld(ret_vld)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a);
        @(negedge clk);
        issue_vld  = 1'b1;
        issue_addr = a;
        @(negedge clk);
        issue_vld  = 1'b0;
    endtask

    // One break request; checks the pulse, the value, then the hold cycle.
    task automatic brk(input string req, input logic mode, input logic [AW-1:0] ma,
                       input logic dbr, input logic slot, input logic [AW-1:0] tgt,
                       input logic [AW-1:0] exp);
        @(negedge clk);
        brk_req = 1'b1; brk_mode = mode; match_addr = ma;
        match_is_dbr = dbr; match_in_slot = slot; branch_target = tgt;
        @(negedge clk);
        brk_req = 1'b0;
        match_addr = ~ma; branch_target = ~tgt;
        chk({req, " vld R5"}, AW'(ret_vld), AW'(1));
        chk(req, ret_addr, exp);
        @(negedge clk);
        chk({req, " pulse end R5"}, AW'(ret_vld), AW'(0));
        chk({req, " hold R6"}, ret_addr, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("reset vld R8", AW'(ret_vld), AW'(0));
        chk("reset addr R8", ret_addr, '0);
        brk("reset hist R8", 1'b0, 32'h100, 1'b0, 1'b1, 32'h0, 32'h0);
    endtask

    task automatic t_before;
        brk("before plain R1", 1'b0, 32'h0000_1000, 1'b0, 1'b0, 32'h9000, 32'h0000_1000);
        brk("before dbr R1", 1'b0, 32'h0000_2004, 1'b1, 1'b0, 32'h9000, 32'h0000_2004);
        issue(32'h0000_3000);
        brk("before slot R2", 1'b0, 32'h0000_3002, 1'b0, 1'b1, 32'h9000, 32'h0000_3000);
        brk("before slot+dbr R2", 1'b0, 32'h0000_3002, 1'b1, 1'b1, 32'h9000, 32'h0000_3000);
    endtask

    task automatic t_after;
        brk("after seq R3", 1'b1, 32'h0000_4000, 1'b0, 1'b0, 32'h9000, 32'h0000_4002);
        brk("after wrap R3", 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b0, 32'h9000, 32'h0);
        brk("after dbr R4", 1'b1, 32'h0000_5000, 1'b1, 1'b0, 32'hA000_0040, 32'hA000_0040);
        brk("after slot R4", 1'b1, 32'h0000_5002, 1'b0, 1'b1, 32'hB000_0080, 32'hB000_0080);
    endtask

    task automatic t_same_cycle;
        issue(32'h0000_6000);
        @(negedge clk);
        issue_vld = 1'b1; issue_addr = 32'h0000_7000;
        brk_req = 1'b1; brk_mode = 1'b0; match_addr = 32'h0000_6002;
        match_is_dbr = 1'b0; match_in_slot = 1'b1;
        @(negedge clk);
        issue_vld = 1'b0; brk_req = 1'b0;
        chk("same cycle old hist R7", ret_addr, 32'h0000_6000);
        brk("hist updated R7", 1'b0, 32'h0000_7002, 1'b0, 1'b1, 32'h0, 32'h0000_7000);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        brk_req = 1'b1; brk_mode = 1'b1; match_addr = 32'h10;
        match_is_dbr = 1'b0; match_in_slot = 1'b0;
        @(negedge clk);
        chk("b2b first vld R5", AW'(ret_vld), AW'(1));
        chk("b2b first R3", ret_addr, 32'h12);
        match_addr = 32'h20; brk_mode = 1'b0;
        @(negedge clk);
        brk_req = 1'b0;
        chk("b2b second vld R5", AW'(ret_vld), AW'(1));
        chk("b2b second R1", ret_addr, 32'h20);
        @(negedge clk);
        chk("b2b end R5", AW'(ret_vld), AW'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_before();
        t_after();
        t_same_cycle();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule